// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block holds the hazard logic of a five-stage in-order pipeline. It watches the register numbers, write enables and load flags carried by the ID, ID/EX, EX/MEM and MEM/WB stages. From these it produces the operand-source selects for both ALU inputs in EX and for both inputs of the equality comparator that resolves branches in ID. It also drives a single stall line, which holds the PC and IF/ID and places a bubble into ID/EX. A flush line clears IF/ID when a branch is taken.

The equality comparator sits inside the block. The datapath passes in the two register-file read values of the instruction in ID, the ALU result held in EX/MEM and the write-back value held in MEM/WB. The block chooses the operands with its own branch selects and compares them. A branch that needs a value not yet computed waits in ID. The stall line outranks the flush line. A taken branch therefore flushes only in the cycle in which its operands are final and the stall has dropped.

Top module: `hazard_ctrl`

## Requirements
- R1: Each EX select uses the code 0 for the register file, 1 for the EX/MEM result and 2 for the MEM/WB value. It is 1 when the EX/MEM stage writes a nonzero register equal to that EX source.
- R2: An EX select is 2 when MEM/WB writes a nonzero register equal to the source and EX/MEM does not match. When both stages match, EX/MEM wins.
- R3: A source register numbered 0 always gets select 0, in EX and in ID, whatever the later stages write.
- R4: `stall` is 1 whenever the ID/EX stage holds a load whose nonzero destination equals either ID source, for every kind of instruction in ID.
- R5: A branch in ID stalls while ID/EX holds any register-writing instruction whose nonzero destination equals one of the branch sources.
- R6: A branch in ID stalls while EX/MEM holds a load whose nonzero destination equals one of its sources. A load directly ahead of a dependent branch therefore costs two stall cycles, after which the operand comes from MEM/WB.
- R7: Each branch select uses the same codes as R1. It is 1 when EX/MEM holds a non-load write to the source, else 2 on a MEM/WB match, else 0.
- R8: `flush` is 1 when the ID instruction is a branch, `stall` is 0, and the two forwarded comparator operands are equal. It is 0 when the ID instruction is not a branch.
- R9: `flush` is never 1 in a cycle in which `stall` is 1. A taken branch flushes in the first cycle after its stall drops.
- R10: Without a load in ID/EX, an instruction in ID that is not a branch is never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst_n | input | 1 | Active-low reset, gates the embedded checks |
| id_src1 | input | RW | First source register of the instruction in ID |
| id_src2 | input | RW | Second source register of the instruction in ID |
| id_branch | input | 1 | Instruction in ID is a compare-equal branch |
| id_val1 | input | XLEN | Register-file value read for `id_src1` |
| id_val2 | input | XLEN | Register-file value read for `id_src2` |
| ex_src1 | input | RW | First source register held in ID/EX |
| ex_src2 | input | RW | Second source register held in ID/EX |
| ex_dst | input | RW | Destination register held in ID/EX |
| ex_we | input | 1 | ID/EX instruction writes a register |
| ex_load | input | 1 | ID/EX instruction reads memory |
| mem_dst | input | RW | Destination register held in EX/MEM |
| mem_we | input | 1 | EX/MEM instruction writes a register |
| mem_load | input | 1 | EX/MEM instruction reads memory |
| mem_result | input | XLEN | ALU result held in EX/MEM |
| wb_dst | input | RW | Destination register held in MEM/WB |
| wb_we | input | 1 | MEM/WB instruction writes a register |
| wb_value | input | XLEN | Value about to be written back from MEM/WB |
| alu_sel1 | output | 2 | Source select for the first ALU operand |
| alu_sel2 | output | 2 | Source select for the second ALU operand |
| cmp_sel1 | output | 2 | Source select for the first comparator operand |
| cmp_sel2 | output | 2 | Source select for the second comparator operand |
| stall | output | 1 | Hold PC and IF/ID, insert a bubble into ID/EX |
| flush | output | 1 | Clear IF/ID after a taken branch |

## Verification
Stall and flush can be requested in the same cycle. This happens when a branch whose operands already compare equal depends on a producer still in ID/EX, or on a load in EX/MEM. The sweeps build exactly these cases: every combination of producer kinds and register matches is run with branch data chosen so that the selected operands compare equal in some cases and differ in others. For each case the bench expects `flush` low while `stall` is high. A directed sequence then moves a load from ID/EX to EX/MEM to MEM/WB ahead of an equal-comparing branch. The bench expects two stall cycles with no flush, followed by exactly one cycle with flush high and the comparator fed from MEM/WB.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;
  // operand source codes shared by EX and ID selects
  typedef enum logic [1:0] {
    SRC_RF    = 2'd0,
    SRC_EXMEM = 2'd1,
    SRC_MEMWB = 2'd2
  } src_sel_e;
endpackage

// File: rtl/hz_src_pick.sv
`timescale 1ns/1ps
// Chooses the source of one operand from later pipeline stages.
module hz_src_pick #(
  parameter int RW = 5
) (
  input  logic [RW-1:0]     src,
  input  logic [RW-1:0]     near_dst,
  input  logic              near_ok,
  input  logic [RW-1:0]     far_dst,
  input  logic              far_ok,
  output hz_pkg::src_sel_e  sel
);
  logic src_live;
  logic near_hit;
  logic far_hit;

  always_comb begin
    src_live = (src != '0);
    near_hit = src_live && near_ok && (near_dst == src);
    far_hit  = src_live && far_ok  && (far_dst  == src);
    if (near_hit)      sel = hz_pkg::SRC_EXMEM;
    else if (far_hit)  sel = hz_pkg::SRC_MEMWB;
    else               sel = hz_pkg::SRC_RF;
  end
endmodule

// File: rtl/hz_stall_eval.sv
`timescale 1ns/1ps
// Decides whether the instruction in ID must wait.
module hz_stall_eval #(
  parameter int RW = 5,
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0][RW-1:0] id_src,
  input  logic                    id_branch,
  input  logic [RW-1:0]           ex_dst,
  input  logic                    ex_we,
  input  logic                    ex_load,
  input  logic [RW-1:0]           mem_dst,
  input  logic                    mem_we,
  input  logic                    mem_load,
  output logic                    stall
);
  logic [NSRC-1:0] ex_hit;
  logic [NSRC-1:0] mem_hit;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    always_comb begin
      ex_hit[k]  = (ex_dst  != '0) && (ex_dst  == id_src[k]);
      mem_hit[k] = (mem_dst != '0) && (mem_dst == id_src[k]);
    end
  end

  logic load_use;
  logic br_wait_ex;
  logic br_wait_mem;

  always_comb begin
    load_use    = ex_load && (|ex_hit);
    br_wait_ex  = id_branch && ex_we && (|ex_hit);
    br_wait_mem = id_branch && mem_we && mem_load && (|mem_hit);
    stall       = load_use || br_wait_ex || br_wait_mem;
  end
endmodule

// File: rtl/hz_branch_cmp.sv
`timescale 1ns/1ps
// Equality comparator for ID branch resolution with forwarded operands.
module hz_branch_cmp #(
  parameter int XLEN = 32,
  parameter int NSRC = 2
) (
  input  hz_pkg::src_sel_e [NSRC-1:0] sel,
  input  logic [NSRC-1:0][XLEN-1:0]   rf_val,
  input  logic [XLEN-1:0]             near_val,
  input  logic [XLEN-1:0]             far_val,
  output logic                        equal
);
  logic [NSRC-1:0][XLEN-1:0] opnd;

  for (genvar k = 0; k < NSRC; k++) begin : g_mux
    always_comb begin
      unique case (sel[k])
        hz_pkg::SRC_EXMEM: opnd[k] = near_val;
        hz_pkg::SRC_MEMWB: opnd[k] = far_val;
        default:           opnd[k] = rf_val[k];
      endcase
    end
  end

  always_comb equal = (opnd[0] == opnd[1]);
endmodule

// File: rtl/hazard_ctrl.sv
`timescale 1ns/1ps
// Hazard detection, forwarding and ID-stage branch resolution.
module hazard_ctrl #(
  parameter  int NREG = 32,
  parameter  int XLEN = 32,
  localparam int RW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RW-1:0]   id_src1,
  input  logic [RW-1:0]   id_src2,
  input  logic            id_branch,
  input  logic [XLEN-1:0] id_val1,
  input  logic [XLEN-1:0] id_val2,
  input  logic [RW-1:0]   ex_src1,
  input  logic [RW-1:0]   ex_src2,
  input  logic [RW-1:0]   ex_dst,
  input  logic            ex_we,
  input  logic            ex_load,
  input  logic [RW-1:0]   mem_dst,
  input  logic            mem_we,
  input  logic            mem_load,
  input  logic [XLEN-1:0] mem_result,
  input  logic [RW-1:0]   wb_dst,
  input  logic            wb_we,
  input  logic [XLEN-1:0] wb_value,
  output logic [1:0]      alu_sel1,
  output logic [1:0]      alu_sel2,
  output logic [1:0]      cmp_sel1,
  output logic [1:0]      cmp_sel2,
  output logic            stall,
  output logic            flush
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][RW-1:0]   ex_src;
  logic [NSRC-1:0][RW-1:0]   id_src;
  logic [NSRC-1:0][XLEN-1:0] id_val;
  hz_pkg::src_sel_e [NSRC-1:0] alu_sel;
  hz_pkg::src_sel_e [NSRC-1:0] cmp_sel;
  logic mem_alu_ok;
  logic cmp_equal;
  logic hold;

  always_comb begin
    ex_src[0] = ex_src1;
    ex_src[1] = ex_src2;
    id_src[0] = id_src1;
    id_src[1] = id_src2;
    id_val[0] = id_val1;
    id_val[1] = id_val2;
    // a load result is not yet present in EX/MEM
    mem_alu_ok = mem_we && !mem_load;
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_opnd
    hz_src_pick #(.RW(RW)) u_alu_pick (
      .src      (ex_src[k]),
      .near_dst (mem_dst),
      .near_ok  (mem_we),
      .far_dst  (wb_dst),
      .far_ok   (wb_we),
      .sel      (alu_sel[k])
    );
    hz_src_pick #(.RW(RW)) u_cmp_pick (
      .src      (id_src[k]),
      .near_dst (mem_dst),
      .near_ok  (mem_alu_ok),
      .far_dst  (wb_dst),
      .far_ok   (wb_we),
      .sel      (cmp_sel[k])
    );
  end

  hz_stall_eval #(.RW(RW), .NSRC(NSRC)) u_stall (
    .id_src    (id_src),
    .id_branch (id_branch),
    .ex_dst    (ex_dst),
    .ex_we     (ex_we),
    .ex_load   (ex_load),
    .mem_dst   (mem_dst),
    .mem_we    (mem_we),
    .mem_load  (mem_load),
    .stall     (hold)
  );

  hz_branch_cmp #(.XLEN(XLEN), .NSRC(NSRC)) u_cmp (
    .sel      (cmp_sel),
    .rf_val   (id_val),
    .near_val (mem_result),
    .far_val  (wb_value),
    .equal    (cmp_equal)
  );

  always_comb begin
    alu_sel1 = alu_sel[0];
    alu_sel2 = alu_sel[1];
    cmp_sel1 = cmp_sel[0];
    cmp_sel2 = cmp_sel[1];
    stall    = hold;
    // stall outranks flush; the branch retries once operands are final
    flush    = id_branch && !hold && cmp_equal;
  end

  p_near_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && ex_src1 != '0 && mem_dst == ex_src1) |-> alu_sel1 == hz_pkg::SRC_EXMEM);
  p_zero_alu_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_src2 == '0) |-> alu_sel2 == hz_pkg::SRC_RF);
  p_zero_cmp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (id_src1 == '0) |-> cmp_sel1 == hz_pkg::SRC_RF);
  p_load_use_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_load && ex_dst != '0 && ex_dst == id_src2) |-> stall);
  p_no_load_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_load && id_branch) |-> cmp_sel1 != hz_pkg::SRC_EXMEM);
  p_flush_branch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> id_branch);
  p_stall_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !flush);
  p_alu_no_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !id_branch) |-> ex_load);
endmodule

// File: tb/sim_hazard_ctrl.sv
`timescale 1ns/1ps
module sim_hazard_ctrl;
  localparam int NREG = 4;
  localparam int XLEN = 4;
  localparam int RW   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [RW-1:0] id_src1 = '0, id_src2 = '0, ex_src1 = '0, ex_src2 = '0;
  logic [RW-1:0] ex_dst = '0, mem_dst = '0, wb_dst = '0;
  logic id_branch = 1'b0, ex_we = 1'b0, ex_load = 1'b0;
  logic mem_we = 1'b0, mem_load = 1'b0, wb_we = 1'b0;
  logic [XLEN-1:0] id_val1 = '0, id_val2 = '0, mem_result = '0, wb_value = '0;
  logic [1:0] alu_sel1, alu_sel2, cmp_sel1, cmp_sel2;
  logic stall, flush;

  int total = 0;
  int bad = 0;

  hazard_ctrl #(.NREG(NREG), .XLEN(XLEN)) u0 (
    .clk(clk), .rst_n(rst_n),
    .id_src1(id_src1), .id_src2(id_src2), .id_branch(id_branch),
    .id_val1(id_val1), .id_val2(id_val2),
    .ex_src1(ex_src1), .ex_src2(ex_src2), .ex_dst(ex_dst),
    .ex_we(ex_we), .ex_load(ex_load),
    .mem_dst(mem_dst), .mem_we(mem_we), .mem_load(mem_load),
    .mem_result(mem_result),
    .wb_dst(wb_dst), .wb_we(wb_we), .wb_value(wb_value),
    .alu_sel1(alu_sel1), .alu_sel2(alu_sel2),
    .cmp_sel1(cmp_sel1), .cmp_sel2(cmp_sel2),
    .stall(stall), .flush(flush)
  );

  // expected select: 1 = EX/MEM, 2 = MEM/WB, 0 = register file (R1 R2 R3 R7)
  function automatic logic [1:0] exp_sel(logic [RW-1:0] s, logic near_ok,
                                         logic [RW-1:0] nd, logic far_ok,
                                         logic [RW-1:0] fd);
    if (s != 0 && near_ok && nd == s) return 2'd1;
    if (s != 0 && far_ok && fd == s)  return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [XLEN-1:0] pick_val(logic [1:0] sl, logic [XLEN-1:0] rf);
    if (sl == 2'd1) return mem_result;
    if (sl == 2'd2) return wb_value;
    return rf;
  endfunction

  task automatic chk(string req, string what, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // computes every expected output from the requirements and compares
  task automatic check_all();
    logic [1:0] ea1, ea2, eb1, eb2;
    logic e_lu, e_bw, e_stall, e_flush;
    logic exh1, exh2, mh1, mh2;
    ea1 = exp_sel(ex_src1, mem_we, mem_dst, wb_we, wb_dst);
    ea2 = exp_sel(ex_src2, mem_we, mem_dst, wb_we, wb_dst);
    eb1 = exp_sel(id_src1, mem_we && !mem_load, mem_dst, wb_we, wb_dst);
    eb2 = exp_sel(id_src2, mem_we && !mem_load, mem_dst, wb_we, wb_dst);
    exh1 = ex_dst != 0 && ex_dst == id_src1;
    exh2 = ex_dst != 0 && ex_dst == id_src2;
    mh1  = mem_dst != 0 && mem_dst == id_src1;
    mh2  = mem_dst != 0 && mem_dst == id_src2;
    e_lu = ex_load && (exh1 || exh2);                                  // R4
    e_bw = id_branch && ((ex_we && (exh1 || exh2)) ||                  // R5
                         (mem_we && mem_load && (mh1 || mh2)));        // R6
    e_stall = e_lu || e_bw;
    e_flush = id_branch && !e_stall &&
              (pick_val(eb1, id_val1) == pick_val(eb2, id_val2));      // R8 R9
    chk("R1", "alu_sel1", alu_sel1, ea1);
    chk("R2", "alu_sel2", alu_sel2, ea2);
    chk("R7", "cmp_sel1", cmp_sel1, eb1);
    chk("R7", "cmp_sel2", cmp_sel2, eb2);
    chk(id_branch ? "R5" : "R10", "stall", stall, e_stall);
    chk(e_stall ? "R9" : "R8", "flush", flush, e_flush);
  endtask

  task automatic set_kind_ex(int k);
    ex_we = (k != 0);
    ex_load = (k == 2);
  endtask

  task automatic set_kind_mem(int k);
    mem_we = (k != 0);
    mem_load = (k == 2);
  endtask

  initial begin
    #(4 * 190000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset state: all inputs idle, outputs quiet (R1 R8)
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset alu_sel1", alu_sel1, 0);
    chk("R7", "reset cmp_sel1", cmp_sel1, 0);
    chk("R4", "reset stall", stall, 0);
    chk("R8", "reset flush", flush, 0);
    rst_n = 1'b1;

    // sweep A: EX forwarding, priority and register 0 (R1 R2 R3)
    for (int mk = 0; mk < 3; mk++) begin
      for (int w = 0; w < 2; w++) begin
        for (int v = 0; v < 256; v++) begin
          @(posedge clk); #1;
          set_kind_mem(mk);
          wb_we = w[0];
          ex_src1 = v[1:0]; ex_src2 = v[3:2];
          mem_dst = v[5:4]; wb_dst = v[7:6];
          @(negedge clk);
          check_all();
        end
      end
    end

    // sweep B: stall, branch selects, flush, stall against flush (R3..R10)
    ex_src1 = '0; ex_src2 = '0;
    for (int ek = 0; ek < 3; ek++) begin
      for (int mk = 0; mk < 3; mk++) begin
        for (int v = 0; v < 8192; v++) begin
          @(posedge clk); #1;
          set_kind_ex(ek);
          set_kind_mem(mk);
          id_src1 = v[1:0]; id_src2 = v[3:2];
          ex_dst = v[5:4]; mem_dst = v[7:6]; wb_dst = v[9:8];
          id_branch = v[10];
          wb_we = v[11];
          id_val1 = 4'd6;
          id_val2 = v[12] ? 4'd6 : 4'd9;
          mem_result = 4'd9;
          wb_value = 4'd6;
          @(negedge clk);
          check_all();
        end
      end
    end

    // directed R6: load then dependent equal branch, two stalls then one flush
    @(posedge clk); #1;
    set_kind_ex(2); ex_dst = 2'd1;
    set_kind_mem(0); mem_dst = 2'd0; wb_we = 1'b0; wb_dst = 2'd0;
    id_branch = 1'b1; id_src1 = 2'd1; id_src2 = 2'd2;
    id_val1 = 4'd3; id_val2 = 4'd5; mem_result = 4'd0; wb_value = 4'd5;
    @(negedge clk);
    chk("R6", "stall load in EX", stall, 1);
    chk("R9", "flush load in EX", flush, 0);
    @(posedge clk); #1;
    set_kind_ex(0); ex_dst = 2'd0;
    set_kind_mem(2); mem_dst = 2'd1; mem_result = 4'd12;
    @(negedge clk);
    chk("R6", "stall load in MEM", stall, 1);
    chk("R9", "flush load in MEM", flush, 0);
    chk("R6", "cmp_sel1 load in MEM", cmp_sel1, 0);
    @(posedge clk); #1;
    set_kind_mem(0); mem_dst = 2'd0;
    wb_we = 1'b1; wb_dst = 2'd1;
    @(negedge clk);
    chk("R6", "stall load in WB", stall, 0);
    chk("R6", "cmp_sel1 load in WB", cmp_sel1, 2);
    chk("R9", "flush after release", flush, 1);

    // directed R5: ALU producer in EX, equal branch waits one cycle
    @(posedge clk); #1;
    wb_we = 1'b0; wb_dst = 2'd0;
    set_kind_ex(1); ex_dst = 2'd2;
    id_val1 = 4'd7; id_val2 = 4'd7;
    @(negedge clk);
    chk("R5", "stall alu in EX", stall, 1);
    chk("R9", "flush alu in EX", flush, 0);
    @(posedge clk); #1;
    set_kind_ex(0); ex_dst = 2'd0;
    set_kind_mem(1); mem_dst = 2'd2; mem_result = 4'd7;
    @(negedge clk);
    chk("R7", "cmp_sel2 alu in MEM", cmp_sel2, 1);
    chk("R8", "flush alu in MEM", flush, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule